// File: doc/BRIEF.md
# Fractional Audio Master Clock Generator

This block derives the timing for an audio serial port from a single system clock. A 2-bit prescale setting first turns the system clock into a slower peripheral-rate enable. A fractional rate multiplier then scales that rate by X/Y, and a halving stage turns the result into an audio master clock (MCLK) rate. An integer divider, programmed with N and dividing by N+1, turns MCLK into the serial bit-clock rate.

A source select can replace the locally made MCLK with MCLK events that arrive from outside the block. A separate output enable decides whether MCLK events reach the MCLK output. Every output is a single-cycle clock-enable pulse in the system clock domain, so the downstream serializer and pin logic stay fully synchronous.

The fractional stage is an accumulator. On each peripheral enable it adds the effective X, and it subtracts Y each time the sum reaches Y. A change to X, Y or N restarts the accumulator, the halving flop and the bit counter, so the new rate starts from a known phase.

Top module: `amclk_gen`

## Requirements
- R1: Prescale code 2'b01 gives a peripheral enable on every system cycle, 2'b10 on every 2nd cycle, 2'b00 on every 4th cycle and 2'b11 on every 8th cycle.
- R2: With X and Y both nonzero and X <= Y, after P peripheral enables counted from a restart, the number of local MCLK pulses is floor(floor(P*X/Y)/2).
- R3: If X is zero or Y is zero, no local MCLK pulse is produced.
- R4: If X > Y, the rate is the rate for X = Y, which is one MCLK pulse per two peripheral enables.
- R5: After M MCLK pulses counted from a restart, the number of bit-clock pulses is floor(M/(N+1)), where N is the 8-bit bit-rate value.
- R6: Source code 2'b10 makes mclk_tick follow ext_mclk_tick cycle for cycle. Every other source code selects the local fractional divider.
- R7: mclk_out_tick equals mclk_tick when mclk_oe is 1 and stays 0 when mclk_oe is 0. mclk_oe has no effect on mclk_tick or bclk_tick.
- R8: In the cycle in which X, Y or N differs from the value held in the previous cycle, no local MCLK pulse and no bit-clock pulse is produced. From the next cycle the counts of R2 and R5 start again from zero.
- R9: While rst_n is low, mclk_tick, mclk_out_tick and bclk_tick stay 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| presc_sel | input | 2 | Prescale code (see R1) |
| rate_x | input | 8 | Fractional multiplier numerator X |
| rate_y | input | 8 | Fractional multiplier denominator Y |
| bit_div | input | 8 | Bit-clock divide value N (divides by N+1) |
| src_sel | input | 2 | MCLK source code, 2'b10 selects the external source |
| mclk_oe | input | 1 | Enables MCLK pulses onto mclk_out_tick |
| ext_mclk_tick | input | 1 | External MCLK event, one pulse per MCLK period |
| pclk_tick | output | 1 | Peripheral-rate enable pulse |
| mclk_tick | output | 1 | Selected MCLK pulse |
| mclk_out_tick | output | 1 | MCLK pulse gated by mclk_oe |
| bclk_tick | output | 1 | Bit-clock pulse |

## Verification
The assertions assume that the external MCLK source delivers single-cycle pulses synchronous to clk. They also assume that every change to X, Y or N is meant as a restart, since the accumulator bound and the bit-counter bound are only claimed once the restart cycle has cleared the old state. The stimulus changes configuration only between measurement windows, and it forces each new configuration to differ in at least one of X, Y or N, so every window begins at a clean restart. It holds ext_mclk_tick low in the restart cycle and during reset.

// File: rtl/amclk_pkg.sv
package amclk_pkg;

  typedef enum logic [1:0] {
    PS_DIV4 = 2'b00,
    PS_DIV1 = 2'b01,
    PS_DIV2 = 2'b10,
    PS_DIV8 = 2'b11
  } presc_e;

  localparam logic [1:0] SRC_EXT = 2'b10;

  // Divide ratio for a prescale code
  function automatic logic [3:0] presc_div(input logic [1:0] code);
    case (code)
      PS_DIV1: presc_div = 4'd1;
      PS_DIV2: presc_div = 4'd2;
      PS_DIV4: presc_div = 4'd4;
      default: presc_div = 4'd8;
    endcase
  endfunction

endpackage

// File: rtl/amclk_prescale.sv
module amclk_prescale
  import amclk_pkg::*;
#(
  parameter int CNT_W = 3
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] sel,
  output logic       tick
);
  localparam int DW = CNT_W + 1;

  logic [CNT_W-1:0] cnt;
  logic [DW-1:0]    last_val;
  logic             wrap;

  always_comb begin
    last_val = DW'(presc_div(sel) - 4'd1);
    wrap     = ({1'b0, cnt} >= last_val);
  end

  assign tick = wrap;

  always_ff @(posedge clk) begin
    if (!rst_n)     cnt <= '0;
    else if (wrap)  cnt <= '0;
    else            cnt <= cnt + 1'b1;
  end

  AST_PCLK_SPACED: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && sel != PS_DIV1) |=> (sel == PS_DIV1 || !tick)); // R1

endmodule

// File: rtl/amclk_frac.sv
module amclk_frac #(
  parameter int RW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          pclk_tick,
  input  logic          clr,
  input  logic [RW-1:0] rate_x,
  input  logic [RW-1:0] rate_y,
  output logic          mclk_tick
);
  // X above Y behaves as X equal to Y
  function automatic logic [RW-1:0] eff_x(input logic [RW-1:0] x,
                                          input logic [RW-1:0] y);
    eff_x = (x > y) ? y : x;
  endfunction

  logic [RW-1:0] acc;
  logic          phase;
  logic [RW-1:0] xe;
  logic [RW:0]   sum;
  logic [RW:0]   diff;
  logic          run;
  logic          hit;
  logic          frac_pulse;

  always_comb begin
    xe         = eff_x(rate_x, rate_y);
    sum        = {1'b0, acc} + {1'b0, xe};
    diff       = sum - {1'b0, rate_y};
    run        = (rate_x != '0) && (rate_y != '0);
    hit        = (sum >= {1'b0, rate_y});
    frac_pulse = pclk_tick && run && !clr && hit;
  end

  assign mclk_tick = frac_pulse && phase;

  always_ff @(posedge clk) begin
    if (!rst_n || clr) begin
      acc   <= '0;
      phase <= 1'b0;
    end else begin
      if (pclk_tick && run)
        acc <= hit ? diff[RW-1:0] : sum[RW-1:0];
      if (frac_pulse)
        phase <= ~phase;
    end
  end

  AST_ACC_BELOW_Y: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr && run) |-> (acc < rate_y)); // R2
  AST_HALF_RATE: assert property (@(posedge clk) disable iff (!rst_n)
    mclk_tick |=> !mclk_tick); // R2
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!run && !clr) |=> (acc == $past(acc))); // R3
  AST_CLAMP: assert property (@(posedge clk) disable iff (!rst_n)
    xe <= rate_y); // R4

endmodule

// File: rtl/amclk_bitdiv.sv
module amclk_bitdiv #(
  parameter int RW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick_in,
  input  logic          clr,
  input  logic [RW-1:0] div_n,
  output logic          bclk_tick
);
  logic [RW-1:0] cnt;
  logic          at_end;

  assign at_end    = (cnt == div_n);
  assign bclk_tick = tick_in && !clr && at_end;

  always_ff @(posedge clk) begin
    if (!rst_n || clr)  cnt <= '0;
    else if (tick_in)   cnt <= at_end ? '0 : cnt + 1'b1;
  end

  AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    !clr |-> (cnt <= div_n)); // R5

endmodule

// File: rtl/amclk_gen.sv
module amclk_gen
  import amclk_pkg::*;
#(
  parameter int RATE_W   = 8,
  parameter int PS_CNT_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        presc_sel,
  input  logic [RATE_W-1:0] rate_x,
  input  logic [RATE_W-1:0] rate_y,
  input  logic [RATE_W-1:0] bit_div,
  input  logic [1:0]        src_sel,
  input  logic              mclk_oe,
  input  logic              ext_mclk_tick,
  output logic              pclk_tick,
  output logic              mclk_tick,
  output logic              mclk_out_tick,
  output logic              bclk_tick
);
  localparam int CFG_W = 3 * RATE_W;

  logic [CFG_W-1:0] cfg_now;
  logic [CFG_W-1:0] cfg_q;
  logic             cfg_chg;
  logic             loc_tick;
  logic             sel_tick;

  assign cfg_now = {rate_x, rate_y, bit_div};
  assign cfg_chg = (cfg_now != cfg_q);

  always_ff @(posedge clk) begin
    if (!rst_n) cfg_q <= '0;
    else        cfg_q <= cfg_now;
  end

  amclk_prescale #(.CNT_W(PS_CNT_W)) u_presc (
    .clk  (clk),
    .rst_n(rst_n),
    .sel  (presc_sel),
    .tick (pclk_tick)
  );

  amclk_frac #(.RW(RATE_W)) u_frac (
    .clk      (clk),
    .rst_n    (rst_n),
    .pclk_tick(pclk_tick),
    .clr      (cfg_chg),
    .rate_x   (rate_x),
    .rate_y   (rate_y),
    .mclk_tick(loc_tick)
  );

  assign sel_tick      = rst_n && ((src_sel == SRC_EXT) ? ext_mclk_tick : loc_tick);
  assign mclk_tick     = sel_tick;
  assign mclk_out_tick = sel_tick && mclk_oe;

  amclk_bitdiv #(.RW(RATE_W)) u_bdiv (
    .clk      (clk),
    .rst_n    (rst_n),
    .tick_in  (sel_tick),
    .clr      (cfg_chg),
    .div_n    (bit_div),
    .bclk_tick(bclk_tick)
  );

  AST_RESTART_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_chg |-> (!loc_tick && !bclk_tick)); // R8
  AST_BCLK_ON_MCLK: assert property (@(posedge clk) disable iff (!rst_n)
    bclk_tick |-> mclk_tick); // R5

endmodule

// File: tb/amclk_gen_bench.sv
`timescale 1ns/1ps
module amclk_gen_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] presc_sel = 2'b01;
  logic [7:0] rate_x = 8'd0;
  logic [7:0] rate_y = 8'd0;
  logic [7:0] bit_div = 8'd0;
  logic [1:0] src_sel = 2'b00;
  logic       mclk_oe = 1'b0;
  logic       ext_mclk_tick = 1'b0;
  logic       pclk_tick, mclk_tick, mclk_out_tick, bclk_tick;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #10 clk = ~clk;

  amclk_gen u_amclk_gen (
    .clk(clk), .rst_n(rst_n), .presc_sel(presc_sel), .rate_x(rate_x),
    .rate_y(rate_y), .bit_div(bit_div), .src_sel(src_sel), .mclk_oe(mclk_oe),
    .ext_mclk_tick(ext_mclk_tick), .pclk_tick(pclk_tick), .mclk_tick(mclk_tick),
    .mclk_out_tick(mclk_out_tick), .bclk_tick(bclk_tick)
  );

  function automatic int ps_ratio(input logic [1:0] c);
    if (c == 2'b01) return 1;
    if (c == 2'b10) return 2;
    if (c == 2'b00) return 4;
    return 8;
  endfunction

  function automatic int want_mclk(input int p, input int x, input int y);
    int xx;
    if (x == 0 || y == 0) return 0;
    xx = (x > y) ? y : x;
    return ((p * xx) / y) / 2;
  endfunction

  function automatic int want_bclk(input int m, input int n);
    return m / (n + 1);
  endfunction

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  // apply a configuration at a negedge; the restart happens at the next posedge
  task automatic apply(input logic [1:0] ps, input int x, input int y,
                       input int n, input logic [1:0] src, input logic oe);
    @(negedge clk);
    presc_sel = ps; rate_x = x[7:0]; rate_y = y[7:0]; bit_div = n[7:0];
    src_sel = src; mclk_oe = oe; ext_mclk_tick = 1'b0;
    @(posedge clk);
  endtask

  task automatic run_window(input int ncyc, input bit drive_ext,
                            output int p, output int m, output int mo,
                            output int b, output int e);
    p = 0; m = 0; mo = 0; b = 0; e = 0;
    for (int i = 0; i < ncyc; i++) begin
      @(negedge clk);
      ext_mclk_tick = drive_ext ? (($urandom % 3) == 0) : 1'b0;
      #1;
      p  += int'(pclk_tick);
      m  += int'(mclk_tick);
      mo += int'(mclk_out_tick);
      b  += int'(bclk_tick);
      e  += int'(ext_mclk_tick);
    end
    @(negedge clk);
    ext_mclk_tick = 1'b0;
  endtask

  task automatic rate_case(input string tag, input logic [1:0] ps, input int x,
                           input int y, input int n, input logic oe, input int ncyc);
    int p, m, mo, b, e;
    apply(ps, x, y, n, 2'b00, oe);
    run_window(ncyc, 1'b0, p, m, mo, b, e);
    check({tag, " mclk count"}, m, want_mclk(p, x, y));
    check({tag, " R5 bclk count"}, b, want_bclk(m, n));
    check({tag, " R7 out gate"}, mo, oe ? m : 0);
  endtask

  initial begin
    int gap, p, m, mo, b, e;
    int px, py, pn;
    void'($urandom(32'd24681));
    rate_x = 8'd3; rate_y = 8'd5; presc_sel = 2'b01;
    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      // R9: quiet during reset
      if (i == 5) begin
        check("R9 mclk_tick in reset", int'(mclk_tick), 0);
        check("R9 bclk_tick in reset", int'(bclk_tick), 0);
        check("R9 mclk_out_tick in reset", int'(mclk_out_tick), 0);
      end
    end
    rst_n = 1'b1;

    // R1: spacing of peripheral enables per prescale code
    for (int c = 0; c < 4; c++) begin
      @(negedge clk);
      presc_sel = c[1:0];
      repeat (10) @(negedge clk);
      while (!pclk_tick) @(negedge clk);
      gap = 0;
      do begin @(negedge clk); gap++; end while (!pclk_tick);
      check($sformatf("R1 pclk spacing code %0d", c), gap, ps_ratio(c[1:0]));
    end

    // R2 directed: exact half and fractional rates
    rate_case("R2 x=y div1", 2'b01, 9, 9, 0, 1'b1, 400);
    rate_case("R2 x=3 y=7", 2'b10, 3, 7, 2, 1'b1, 1200);
    rate_case("R2 x=1 y=255", 2'b01, 1, 255, 0, 1'b1, 2000);
    // R3: zero numerator or denominator stops MCLK
    rate_case("R3 x=0", 2'b01, 0, 20, 1, 1'b1, 500);
    rate_case("R3 y=0", 2'b01, 40, 0, 1, 1'b1, 500);
    // R4: X above Y clamps
    rate_case("R4 x=200 y=50", 2'b00, 200, 50, 3, 1'b1, 800);
    apply(2'b01, 255, 1, 4, 2'b00, 1'b1);
    run_window(300, 1'b0, p, m, mo, b, e);
    check("R4 x>y half of pclk", m, p / 2);
    // R7: enable off
    rate_case("R7 oe off", 2'b01, 5, 11, 1, 1'b0, 600);

    // R8: mid-run change leaves accumulator non-zero, then restart
    apply(2'b01, 3, 7, 5, 2'b00, 1'b1);
    run_window(37, 1'b0, p, m, mo, b, e);
    rate_case("R8 restart x=5 y=7", 2'b01, 5, 7, 5, 1'b1, 700);
    rate_case("R8 restart n only", 2'b01, 5, 7, 2, 1'b1, 700);

    // R6: external source, with other codes staying local
    apply(2'b01, 4, 9, 3, 2'b10, 1'b1);
    run_window(600, 1'b1, p, m, mo, b, e);
    check("R6 ext mclk follows input", m, e);
    check("R6 ext R5 bclk count", b, want_bclk(e, 3));
    check("R6 ext R7 out gate", mo, m);
    apply(2'b01, 4, 9, 6, 2'b11, 1'b0);
    run_window(600, 1'b1, p, m, mo, b, e);
    check("R6 code 11 stays local", m, want_mclk(p, 4, 9));
    check("R6 code 11 R7 out gate", mo, 0);

    // Random configurations, each differing from the last in X, Y or N
    px = 4; py = 9; pn = 6;
    for (int t = 0; t < 24; t++) begin
      logic [1:0] ps;
      int x, y, n;
      logic oe;
      ps = 2'($urandom);
      oe = 1'($urandom);
      do begin
        x = int'($urandom % 256);
        y = int'($urandom % 256);
        if (($urandom % 4) != 0 && x > y) begin int tmp = x; x = y; y = tmp; end
        n = int'($urandom % 16);
      end while (x == px && y == py && n == pn);
      px = x; py = y; pn = n;
      rate_case($sformatf("R2 rand %0d", t), ps, x, y, n, oe, 1500);
    end

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(20 * 200000);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule